// File: doc/BRIEF.md
# Serial Channel Indexed Control Port

This block is the host-facing register front end of one serial channel. The host sees two byte-wide locations, chosen by a single address bit. The data location (address 1) leads straight to the transmit and receive holding latches. The control location (address 0) is steered by an internal register pointer. While the pointer is zero, a control write loads the pointer with a register number and a control read returns the status byte. Once the pointer is nonzero, exactly one control read or write reaches the selected register, and the pointer then falls back to zero. Every indexed access therefore takes two host operations. A plain status poll takes one.

The write registers hold the channel's configuration. Registers 12 and 13 form the 16-bit baud time constant that the bit-rate generator uses. A serial shifter outside this block picks bytes up from the transmit holding register through a pending/taken handshake. The same shifter delivers received bytes with a one-cycle valid pulse. The block signals each host read of the received byte with an acknowledge strobe.

Top module: `serial_index_port`

## Requirements
- R1: After synchronous reset the pointer is 0, the status byte reads 0x04 (transmit empty, nothing received), all write registers and the baud time constant are 0, tx_pending is 0 and rx_ack is 0.
- R2: A control read (bus_addr=0) while the pointer is 0 returns the status byte. Bit 0 is receive-available, bit 2 is transmit-empty, and every other bit is 0. bus_rdata shows a read's result from the clock edge that accepts the read and holds it until the next read.
- R3: A control write while the pointer is 0 loads the pointer from bus_wdata[3:0]. Bits 7:4 are ignored, and no register changes.
- R4: A control write while the pointer is n (n≠0) stores bus_wdata into write register n and returns the pointer to 0.
- R5: A control read while the pointer is n (n≠0) returns the contents of write register n and returns the pointer to 0.
- R6: baud_tc always equals {write register 13, write register 12}.
- R7: A data-port write loads tx_hold with bus_wdata and sets tx_pending, which clears status bit 2.
- R8: A tx_taken pulse clears tx_pending (status bit 2 becomes 1). If a data-port write occurs in the same cycle, the write wins and tx_pending stays 1.
- R9: An rx_valid pulse latches rx_byte and sets status bit 0. A data-port read returns the latched byte, clears bit 0, and raises rx_ack for exactly the following cycle. If rx_valid arrives in the same cycle as the read, the new byte is latched and bit 0 stays set.
- R10: When bus_rd and bus_wr are both high, only the read is performed, and the write has no effect.
- R11: A control write of a value whose low four bits are 0 leaves the pointer at 0, so the next control access is again a status read or a pointer load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects the control location, 1 selects the data location |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |
| tx_hold | output | 8 | Transmit holding byte for the shifter |
| tx_pending | output | 1 | Transmit holding register holds an unsent byte |
| tx_taken | input | 1 | Shifter has taken the pending byte |
| rx_byte | input | 8 | Byte delivered by the receive shifter |
| rx_valid | input | 1 | One-cycle pulse qualifying rx_byte |
| rx_ack | output | 1 | Pulse after the host reads the received byte |
| baud_tc | output | 16 | Baud time constant from registers 13 and 12 |

## Verification
The bench builds the block with its default of sixteen registers, which gives a 4-bit pointer. Every pointer value, including the baud pair at 12 and 13 and the unused top register 15, can then be reached by random pointer loads whose upper nibble is also random. This lets the bench show that bits 7:4 are dropped. At this size the random mix of index writes, register accesses, data-port traffic and shifter pulses covers the simultaneous cases: read with write, taken with load, and valid with read.

// File: rtl/sccp_pkg.sv
package sccp_pkg;

    localparam int BYTE_W      = 8;
    localparam int BAUD_LO_SEL = 12;
    localparam int BAUD_HI_SEL = 13;
    localparam int ST_RX_BIT   = 0;
    localparam int ST_TX_BIT   = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        PORT_CTRL = 1'b0,
        PORT_DATA = 1'b1
    } port_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        port_e    port;
        byte_t    data;
    } host_op_t;

    function automatic byte_t pack_status(input logic rx_avail, input logic tx_empty);
        byte_t s;
        s            = '0;
        s[ST_RX_BIT] = rx_avail;
        s[ST_TX_BIT] = tx_empty;
        return s;
    endfunction

    function automatic host_op_t decode_op(input logic rd, input logic wr,
                                           input logic addr, input byte_t wdata);
        host_op_t op;
        op.port = port_e'(addr);
        op.data = wdata;
        if (rd)      op.kind = OP_READ;
        else if (wr) op.kind = OP_WRITE;
        else         op.kind = OP_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/sccp_index_ptr.sv
module sccp_index_ptr
    import sccp_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  host_op_t         op,
    output logic [PTR_W-1:0] ptr,
    output logic             reg_we
);

    logic [PTR_W-1:0] ptr_q;
    logic             ctrl_rd;
    logic             ctrl_wr;

    always_comb begin
        ctrl_rd = (op.kind == OP_READ)  && (op.port == PORT_CTRL);
        ctrl_wr = (op.kind == OP_WRITE) && (op.port == PORT_CTRL);
        reg_we  = ctrl_wr && (ptr_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ctrl_rd) begin
            ptr_q <= '0;
        end else if (ctrl_wr) begin
            if (ptr_q == '0) ptr_q <= op.data[PTR_W-1:0];
            else             ptr_q <= '0;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/sccp_wreg_file.sv
module sccp_wreg_file
    import sccp_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int PTR_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [PTR_W-1:0]              sel,
    input  byte_t                         wdata,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] regs
);

    // Register 0 is never writable: a control write with pointer 0 is a pointer load.
    assign regs[0] = '0;

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
        byte_t q;
        always_ff @(posedge clk) begin
            if (rst)                                   q <= '0;
            else if (we && (sel == PTR_W'(i)))         q <= wdata;
        end
        assign regs[i] = q;
    end

endmodule

// File: rtl/sccp_flags.sv
module sccp_flags
    import sccp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  host_op_t op,
    input  logic     tx_taken,
    input  byte_t    rx_byte,
    input  logic     rx_valid,
    output byte_t    tx_hold,
    output logic     tx_empty,
    output byte_t    rx_hold,
    output logic     rx_avail,
    output logic     rx_ack
);

    logic data_wr;
    logic data_rd;

    always_comb begin
        data_wr = (op.kind == OP_WRITE) && (op.port == PORT_DATA);
        data_rd = (op.kind == OP_READ)  && (op.port == PORT_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_hold  <= '0;
            tx_empty <= 1'b1;
        end else if (data_wr) begin
            tx_hold  <= op.data;
            tx_empty <= 1'b0;
        end else if (tx_taken) begin
            tx_empty <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_hold  <= '0;
            rx_avail <= 1'b0;
            rx_ack   <= 1'b0;
        end else begin
            rx_ack <= data_rd;
            if (rx_valid) begin
                rx_hold  <= rx_byte;
                rx_avail <= 1'b1;
            end else if (data_rd) begin
                rx_avail <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/serial_index_port.sv
module serial_index_port
    import sccp_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic [7:0]  tx_hold,
    output logic        tx_pending,
    input  logic        tx_taken,
    input  logic [7:0]  rx_byte,
    input  logic        rx_valid,
    output logic        rx_ack,
    output logic [15:0] baud_tc
);

    localparam int PTR_W = $clog2(NUM_REGS);

    host_op_t                        op;
    logic [PTR_W-1:0]                ptr_cur;
    logic                            reg_we;
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
    logic                            tx_empty;
    logic                            rx_avail;
    byte_t                           rx_hold;
    byte_t                           rd_mux;
    byte_t                           rdata_q;

    assign op = decode_op(bus_rd, bus_wr, bus_addr, bus_wdata);

    sccp_index_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ptr    (ptr_cur),
        .reg_we (reg_we)
    );

    sccp_wreg_file #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .sel   (ptr_cur),
        .wdata (op.data),
        .regs  (regs)
    );

    sccp_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .tx_taken (tx_taken),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .tx_hold  (tx_hold),
        .tx_empty (tx_empty),
        .rx_hold  (rx_hold),
        .rx_avail (rx_avail),
        .rx_ack   (rx_ack)
    );

    always_comb begin
        if (op.port == PORT_DATA)  rd_mux = rx_hold;
        else if (ptr_cur == '0)    rd_mux = pack_status(rx_avail, tx_empty);
        else                       rd_mux = regs[ptr_cur];
    end

    always_ff @(posedge clk) begin
        if (rst)                      rdata_q <= '0;
        else if (op.kind == OP_READ)  rdata_q <= rd_mux;
    end

    assign bus_rdata  = rdata_q;
    assign tx_pending = ~tx_empty;
    assign baud_tc    = {regs[BAUD_HI_SEL], regs[BAUD_LO_SEL]};

endmodule

// File: rtl/serial_index_port_chk.sv
module serial_index_port_chk #(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_addr,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic             tx_pending,
    input logic             tx_taken,
    input logic             rx_ack,
    input logic [15:0]      baud_tc,
    input logic [PTR_W-1:0] ptr_cur
);

    // R3: pointer load from the low nibble while the pointer is idle
    a_r3_ptr_load: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && !bus_addr && ptr_cur == '0)
        |=> (ptr_cur == $past(bus_wdata[PTR_W-1:0])));

    // R4: pointer returns to zero after an indexed write
    a_r4_ptr_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && !bus_addr && ptr_cur != '0) |=> (ptr_cur == '0));

    // R5: pointer returns to zero after any control read
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_addr) |=> (ptr_cur == '0));

    // R6: baud constant changes only through an indexed write
    a_r6_baud_stable: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && !bus_rd && !bus_addr && ptr_cur != '0) |=> $stable(baud_tc));

    // R7: data write leaves a byte pending
    a_r7_tx_pending: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && bus_addr) |=> tx_pending);

    // R8: taken without a new load empties the holding register
    a_r8_tx_taken: assert property (@(posedge clk) disable iff (rst)
        (tx_taken && !(bus_wr && !bus_rd && bus_addr)) |=> !tx_pending);

    // R9: acknowledge follows exactly the data reads
    a_r9_rx_ack: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr) |=> rx_ack);
    a_r9_rx_ack_only: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_addr) |=> !rx_ack);

    // R2: read data holds between reads
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind serial_index_port serial_index_port_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tx_pending (tx_pending),
    .tx_taken   (tx_taken),
    .rx_ack     (rx_ack),
    .baud_tc    (baud_tc),
    .ptr_cur    (ptr_cur)
);

// File: tb/test_serial_index_port.sv
module test_serial_index_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_addr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  tx_hold;
    logic        tx_pending;
    logic        tx_taken = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ack;
    logic [15:0] baud_tc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    logic [7:0] m_regs [16];
    logic [3:0] m_ptr;
    logic       m_txe;
    logic       m_rxa;
    logic [7:0] m_rxb;
    logic [7:0] m_txh;
    logic [7:0] m_rdata;

    always #2 clk = ~clk;

    serial_index_port i_serial_index_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_hold(tx_hold),
        .tx_pending(tx_pending), .tx_taken(tx_taken), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rx_ack(rx_ack), .baud_tc(baud_tc)
    );

    function automatic logic [7:0] exp_status();
        return {5'b0, m_txe, 1'b0, m_rxa};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_regs[i] = '0;
        m_ptr = '0; m_txe = 1'b1; m_rxa = 1'b0; m_rxb = '0; m_txh = '0; m_rdata = '0;
    endtask

    // One bus cycle: drive at negedge, model the edge, compare at the next negedge.
    task automatic step(input bit rd, input bit wr, input bit addr, input logic [7:0] wd,
                        input bit rxv, input logic [7:0] rxb, input bit taken,
                        input string req);
        bit wr_eff;
        bit exp_ack;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        rx_valid = rxv; rx_byte = rxb; tx_taken = taken;
        wr_eff  = wr && !rd;
        exp_ack = rd && addr;
        if (rd) begin
            if (addr)              m_rdata = m_rxb;
            else if (m_ptr == 0)   m_rdata = exp_status();
            else                   m_rdata = m_regs[m_ptr];
        end
        if (rd && !addr) m_ptr = '0;
        if (wr_eff && !addr) begin
            if (m_ptr == 0) m_ptr = wd[3:0];
            else begin m_regs[m_ptr] = wd; m_ptr = '0; end
        end
        if (wr_eff && addr) begin m_txh = wd; m_txe = 1'b0; end
        else if (taken)        m_txe = 1'b1;
        if (rxv) begin m_rxb = rxb; m_rxa = 1'b1; end
        else if (rd && addr) m_rxa = 1'b0;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0; tx_taken = 1'b0;
        check(bus_rdata == m_rdata, req, "bus_rdata", bus_rdata, m_rdata);
        check(rx_ack == exp_ack, "R9", "rx_ack", rx_ack, exp_ack);
        check(tx_pending == !m_txe, "R7/R8 tx_pending", "", tx_pending, !m_txe);
        check(tx_hold == m_txh, "R7", "tx_hold", tx_hold, m_txh);
        check(baud_tc == {m_regs[13], m_regs[12]}, "R6", "baud_tc", baud_tc,
              {m_regs[13], m_regs[12]});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state at the ports
        check(baud_tc == 16'h0, "R1", "baud_tc", baud_tc, 0);
        check(tx_pending == 1'b0, "R1", "tx_pending", tx_pending, 0);
        check(rx_ack == 1'b0, "R1", "rx_ack", rx_ack, 0);
        step(1, 0, 0, 8'h00, 0, 8'h00, 0, "R1 R2 status after reset");
        check(bus_rdata == 8'h04, "R1", "status", bus_rdata, 8'h04);

        // R3: upper nibble ignored, selects 12; R4 store
        step(0, 1, 0, 8'hFC, 0, 8'h00, 0, "R3");
        step(0, 1, 0, 8'h34, 0, 8'h00, 0, "R4");
        step(0, 1, 0, 8'h0D, 0, 8'h00, 0, "R3");
        step(0, 1, 0, 8'h12, 0, 8'h00, 0, "R4");
        check(baud_tc == 16'h1234, "R6", "baud pair", baud_tc, 16'h1234);
        step(1, 0, 0, 8'h00, 0, 8'h00, 0, "R4 pointer back to status");
        // R5 readback, then pointer back to zero
        step(0, 1, 0, 8'h0C, 0, 8'h00, 0, "R3");
        step(1, 0, 0, 8'h00, 0, 8'h00, 0, "R5 readback");
        check(bus_rdata == 8'h34, "R5", "reg12", bus_rdata, 8'h34);
        step(1, 0, 0, 8'h00, 0, 8'h00, 0, "R5 status after readback");
        // R11: zero low nibble keeps the pointer idle
        step(0, 1, 0, 8'h00, 0, 8'h00, 0, "R11");
        step(0, 1, 0, 8'hF0, 0, 8'h00, 0, "R11");
        step(1, 0, 0, 8'h00, 0, 8'h00, 0, "R11 status");
        check(bus_rdata == 8'h04, "R11", "status", bus_rdata, 8'h04);

        // R7 / R8
        step(0, 1, 1, 8'hA5, 0, 8'h00, 0, "R7");
        step(1, 0, 0, 8'h00, 0, 8'h00, 0, "R7 status busy");
        check(bus_rdata == 8'h00, "R7", "status", bus_rdata, 8'h00);
        step(0, 0, 0, 8'h00, 0, 8'h00, 1, "R8");
        step(0, 1, 1, 8'h3C, 0, 8'h00, 1, "R8 load wins over taken");
        step(0, 0, 0, 8'h00, 0, 8'h00, 1, "R8");

        // R9
        step(0, 0, 0, 8'h00, 1, 8'h5A, 0, "R9");
        step(1, 0, 0, 8'h00, 0, 8'h00, 0, "R9 status");
        check(bus_rdata == 8'h05, "R9", "status", bus_rdata, 8'h05);
        step(1, 0, 1, 8'h00, 0, 8'h00, 0, "R9 data read");
        check(bus_rdata == 8'h5A, "R9", "rx byte", bus_rdata, 8'h5A);
        step(1, 0, 0, 8'h00, 0, 8'h00, 0, "R9 bit0 cleared");
        step(0, 0, 0, 8'h00, 1, 8'h11, 0, "R9");
        step(1, 0, 1, 8'h00, 1, 8'h22, 0, "R9 valid with read");
        step(1, 0, 1, 8'h00, 0, 8'h00, 0, "R9 new byte kept");

        // R10: read and write together
        step(1, 1, 0, 8'h05, 0, 8'h00, 0, "R10 ctrl");
        step(1, 0, 0, 8'h00, 0, 8'h00, 0, "R10 pointer untouched");
        step(1, 1, 1, 8'hEE, 0, 8'h00, 0, "R10 data");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int k;
            bit rd, wr, addr, rxv, tk;
            k    = $urandom % 8;
            rd   = (k < 3) || (k == 7);
            wr   = (k >= 3) || ($urandom % 16 == 0);
            addr = ($urandom % 3 == 0);
            rxv  = ($urandom % 6 == 0);
            tk   = ($urandom % 5 == 0);
            step(rd, wr, addr, 8'($urandom), rxv, 8'($urandom), tk,
                 "R2 R3 R4 R5 R10 random");
        end

        finish_run();
    end

endmodule